// File: doc/BRIEF.md
# Fractional Clock-Enable Source Divider

This block picks one clock-enable stream out of ten candidate sources and thins it into a slower enable stream. The divisor has an integer part and a fractional part. Each instance fixes the width of both parts through parameters, so one design serves outputs that need only coarse integer ratios as well as outputs that need fine fractional ratios. The result is one enable pulse stream whose average rate is the selected source rate multiplied by 2^FRAC_W and divided by the divisor.

Configuration arrives as two register words: a control word and a divide word. The control word carries an on/off bit and a 4-bit source number. The divide word carries the integer part from bit 12 upward and the fraction in the FRAC_W bits directly under bit 12. The block registers both words once per cycle. It reports a busy flag that shows whether the block is running. Division uses a phase accumulator, and the accumulator restarts cleanly whenever the selection or the divisor is changed in flight. An instance built with no divider bits passes the selected source straight through.

Top module: `fcmux_div`

## Requirements
- R1: `busy` equals the value `cfg_enable` had at the previous rising clock edge.
- R2: While the captured enable is 0, `clk_en_out` stays 0 and the accumulator is cleared, so the first pulse after re-enabling counts from zero.
- R3: The divisor is `cfg_div[12+INT_W-1 : 12-FRAC_W]`: the integer part in bits 12 upward, the fraction in the FRAC_W bits below bit 12. All other bits of `cfg_div` have no effect on the output.
- R4: On each selected source pulse the accumulator adds 2^FRAC_W. If the sum is at least the divisor, `clk_en_out` is 1 in the next cycle and the divisor is subtracted. Otherwise the sum is kept and no pulse is produced. This gives an average rate of 2^FRAC_W / divisor (for example, divisor 6 with FRAC_W=2 gives 20 outputs per 30 source pulses).
- R5: A captured divisor of zero keeps `clk_en_out` at 0.
- R6: A nonzero divisor below 2^FRAC_W gives exactly one output per selected source pulse.
- R7: Source numbers: 0 is ground, 1 is `xosc_en`, 2 is `dbg_en[0]`, 3 is `dbg_en[1]`, 4 to 9 are `aux_en[0]` to `aux_en[5]`, and 10 to 15 act as ground.
- R8: While enabled, if the incoming source number or divisor field differs from the captured one, the accumulator clears and `clk_en_out` is 0 in the next cycle. The new setting applies from the cycle after that.
- R9: With INT_W=0 and FRAC_W=0, `clk_en_out` is the selected source enable delayed by one cycle and gated by the captured enable.
- R10: After synchronous reset, `busy` and `clk_en_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Control word run bit |
| cfg_src | input | 4 | Control word source number |
| cfg_div | input | REG_W | Divide word (integer part at bit 12, fraction below) |
| xosc_en | input | 1 | Oscillator enable stream (source 1) |
| dbg_en | input | 2 | Test clock enable streams (sources 2, 3) |
| aux_en | input | 6 | Instance-specific enable streams (sources 4 to 9) |
| busy | output | 1 | Running flag, mirrors captured enable |
| clk_en_out | output | 1 | Divided enable stream |

## Verification
The bench aims at the divisor boundaries: a fractional ratio of 1.5, a divisor exactly equal to unity, a divisor below unity, and a zero divisor. A design that lets the accumulator run away below unity would emit extra pulses. A design that divides by a zero divisor would emit pulses where none are due. The bench also places the divisor field with ones in every bit outside it, so a field taken from the wrong bit positions changes the pulse pattern. It changes the divisor while the accumulator holds a remainder, so a missing restart leaves an early pulse. It steps through all sixteen source numbers with the other sources active, so a wrong decode or a missing ground for numbers 10 to 15 shows up as stray or missing output.

// File: rtl/fcmux_pkg.sv
// Package: shared constants for the fractional clock-enable divider.
// Assumes a 4-bit source number and ten wired sources.
package fcmux_pkg;
    localparam int SRC_W        = 4;
    localparam int NUM_SRC      = 10;
    localparam int SRC_GND      = 0;
    localparam int SRC_XOSC     = 1;
    localparam int SRC_DBG0     = 2;
    localparam int SRC_DBG1     = 3;
    localparam int SRC_AUX0     = 4;
    localparam int NUM_DBG      = SRC_AUX0 - SRC_DBG0;
    localparam int NUM_AUX      = NUM_SRC - SRC_AUX0;
    localparam int SRC_SLOTS    = 1 << SRC_W;
    localparam int DIV_INT_LSB  = 12;

    typedef logic [SRC_W-1:0] src_sel_t;

    // Classify a source slot: 0 ground, 1 oscillator, 2 debug, 3 aux, 4 unused.
    function automatic int slot_kind(input int idx);
        if (idx == SRC_GND)                         return 0;
        else if (idx == SRC_XOSC)                   return 1;
        else if (idx >= SRC_DBG0 && idx < SRC_AUX0) return 2;
        else if (idx >= SRC_AUX0 && idx < NUM_SRC)  return 3;
        else                                        return 4;
    endfunction
endpackage

// File: rtl/fcmux_src_sel.sv
// Source selector: maps the source number to one enable stream.
// Assumes slot 0 and slots at NUM_SRC and above are tied to ground.
module fcmux_src_sel
    import fcmux_pkg::*;
(
    input  logic                 xosc_en,
    input  logic [NUM_DBG-1:0]   dbg_en,
    input  logic [NUM_AUX-1:0]   aux_en,
    input  src_sel_t             sel,
    output logic                 sel_en
);
    logic [SRC_SLOTS-1:0] slot_vec;

    // Wire each slot of the table according to its kind.
    for (genvar i = 0; i < SRC_SLOTS; i++) begin : g_slot
        if (slot_kind(i) == 1) begin : g_xosc
            assign slot_vec[i] = xosc_en;
        end else if (slot_kind(i) == 2) begin : g_dbg
            assign slot_vec[i] = dbg_en[i - SRC_DBG0];
        end else if (slot_kind(i) == 3) begin : g_aux
            assign slot_vec[i] = aux_en[i - SRC_AUX0];
        end else begin : g_gnd
            assign slot_vec[i] = 1'b0;
        end
    end

    // Pick the selected slot.
    assign sel_en = slot_vec[sel];
endmodule

// File: rtl/fcmux_frac_acc.sv
// Phase-accumulator divider: adds 2^FRAC_W per input tick and emits one
// registered pulse each time the sum reaches the divisor.
// Assumes run/restart/divisor come from registered configuration.
// With INT_W=FRAC_W=0 it degenerates to a gated one-cycle delay.
module fcmux_frac_acc #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    localparam int DW    = INT_W + FRAC_W,
    localparam int DWP   = (DW > 0) ? DW : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           restart,
    input  logic [DWP-1:0] divisor,
    input  logic           tick,
    output logic           pulse
);
    if (DW == 0) begin : g_bypass
        logic unused_div;
        assign unused_div = ^divisor;

        // Pass the selected enable through, gated and delayed one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) pulse <= 1'b0;
            else        pulse <= run & ~restart & tick;
        end
    end else begin : g_accum
        localparam int AW = DW + 1;
        localparam logic [AW-1:0] UNIT = AW'(1) << FRAC_W;

        logic [AW-1:0] acc;
        logic [AW-1:0] sum;
        logic [AW-1:0] div_ext;
        logic          div_zero;
        logic          below_unit;
        logic          reach;

        // Derive the next accumulator sum and the comparisons.
        always_comb begin
            div_ext    = {1'b0, divisor};
            sum        = acc + UNIT;
            div_zero   = (divisor == '0);
            below_unit = (div_ext < UNIT);
            reach      = (sum >= div_ext);
        end

        // Advance the accumulator and produce the output pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc   <= '0;
                pulse <= 1'b0;
            end else if (!run || restart || div_zero) begin
                acc   <= '0;
                pulse <= 1'b0;
            end else if (below_unit) begin
                acc   <= '0;
                pulse <= tick;
            end else if (tick) begin
                if (reach) begin
                    acc   <= sum - div_ext;
                    pulse <= 1'b1;
                end else begin
                    acc   <= sum;
                    pulse <= 1'b0;
                end
            end else begin
                pulse <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/fcmux_div.sv
// Top: captures the control and divide words, selects a source enable
// and divides it. Assumes 12-FRAC_W >= 0 and 12+INT_W <= REG_W.
module fcmux_div
    import fcmux_pkg::*;
#(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 4,
    parameter int REG_W  = 32,
    localparam int DW    = INT_W + FRAC_W,
    localparam int DWP   = (DW > 0) ? DW : 1,
    localparam int DLO   = DIV_INT_LSB - FRAC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [SRC_W-1:0]   cfg_src,
    input  logic [REG_W-1:0]   cfg_div,
    input  logic               xosc_en,
    input  logic [NUM_DBG-1:0] dbg_en,
    input  logic [NUM_AUX-1:0] aux_en,
    output logic               busy,
    output logic               clk_en_out
);
    logic           en_q;
    src_sel_t       src_q;
    logic [DWP-1:0] div_q;
    logic [DWP-1:0] div_field;
    logic           restart;
    logic           sel_en;
    logic           unused_div_word;

    assign unused_div_word = ^cfg_div;

    // Extract the divisor field anchored at the integer LSB.
    if (DW > 0) begin : g_field
        assign div_field = cfg_div[DLO +: DWP];
    end else begin : g_nofield
        assign div_field = '0;
    end

    // Capture the configuration words once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            src_q <= '0;
            div_q <= '0;
        end else begin
            en_q  <= cfg_enable;
            src_q <= cfg_src;
            div_q <= div_field;
        end
    end

    // Flag an in-flight change of source or divisor.
    always_comb begin
        restart = en_q && ((cfg_src != src_q) || (div_field != div_q));
    end

    assign busy = en_q;

    fcmux_src_sel u_sel (
        .xosc_en (xosc_en),
        .dbg_en  (dbg_en),
        .aux_en  (aux_en),
        .sel     (src_q),
        .sel_en  (sel_en)
    );

    fcmux_frac_acc #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (en_q),
        .restart (restart),
        .divisor (div_q),
        .tick    (sel_en),
        .pulse   (clk_en_out)
    );
endmodule

// File: rtl/fcmux_div_chk.sv
// Checker for fcmux_div, bound to every instance.
module fcmux_div_chk #(
    parameter int DIVW    = 12,
    parameter int HAS_DIV = 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_enable,
    input logic            busy,
    input logic            clk_en_out,
    input logic            en_q,
    input logic [3:0]      src_q,
    input logic [DIVW-1:0] div_q,
    input logic            sel_en
);
    a_r1_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> busy == $past(cfg_enable));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !clk_en_out);

    a_r5_zero_div_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_DIV != 0 && en_q && div_q == '0) |=> !clk_en_out);

    a_r7_ground_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == 4'd0 || src_q >= 4'd10) |=> !clk_en_out);

    a_r4_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_out |-> $past(sel_en));
endmodule

bind fcmux_div fcmux_div_chk #(.DIVW(DWP), .HAS_DIV((DW > 0) ? 1 : 0)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .busy       (busy),
    .clk_en_out (clk_en_out),
    .en_q       (en_q),
    .src_q      (src_q),
    .div_q      (div_q),
    .sel_en     (sel_en)
);

// File: tb/fcmux_div_tb.sv
module fcmux_div_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0;
    logic [3:0]  cfg_src = '0;
    logic [31:0] cfg_div = '0;
    logic        xosc_en = 1'b0;
    logic [1:0]  dbg_en = '0;
    logic [5:0]  aux_en = '0;
    logic        busy, out_main, busy_b, out_byp;

    int checks = 0;
    int fails = 0;
    int rate_cnt = 0;

    typedef struct {
        bit    o;
        bit    b;
        bit    bs;
        string tag;
    } exp_t;
    exp_t sbq[$];

    // Reference model state (INT_W=4, FRAC_W=2 for main; 0/0 for bypass).
    bit       m_en = 0;
    bit [3:0] m_src = 0;
    bit [5:0] m_div = 0;
    int       m_acc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmux_div #(.INT_W(4), .FRAC_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src(cfg_src),
        .cfg_div(cfg_div), .xosc_en(xosc_en), .dbg_en(dbg_en), .aux_en(aux_en),
        .busy(busy), .clk_en_out(out_main)
    );

    fcmux_div #(.INT_W(0), .FRAC_W(0)) u_byp (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_src(cfg_src),
        .cfg_div(cfg_div), .xosc_en(xosc_en), .dbg_en(dbg_en), .aux_en(aux_en),
        .busy(busy_b), .clk_en_out(out_byp)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic bit src_of(input bit [3:0] s, input bit x, input bit [1:0] d, input bit [5:0] a);
        if (s == 1) return x;
        if (s == 2) return d[0];
        if (s == 3) return d[1];
        if (s >= 4 && s <= 9) return a[s-4];
        return 0;
    endfunction

    function automatic bit [31:0] dword(input int v);
        return 32'(v) << 10;
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic cyc(input bit en, input bit [3:0] s, input bit [31:0] dw,
                       input bit x, input bit [1:0] d, input bit [5:0] a, input string tag);
        exp_t e;
        bit sv;
        bit [5:0] fld;
        @(negedge clk);
        cfg_enable = en; cfg_src = s; cfg_div = dw;
        xosc_en = x; dbg_en = d; aux_en = a;
        fld = dw[15:10];
        sv = src_of(m_src, x, d, a);
        e.tag = tag;
        e.bs = en;
        e.b = m_en && (s == m_src) && sv;
        if (!m_en || s != m_src || fld != m_div || m_div == 0) begin
            e.o = 0; m_acc = 0;
        end else if (m_div < 4) begin
            e.o = sv; m_acc = 0;
        end else if (sv) begin
            if (m_acc + 4 >= m_div) begin e.o = 1; m_acc = m_acc + 4 - m_div; end
            else begin e.o = 0; m_acc = m_acc + 4; end
        end else begin
            e.o = 0;
        end
        m_en = en; m_src = s; m_div = fld;
        sbq.push_back(e);
    endtask

    // Monitor: compares design outputs with queued expectations after each edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            if (out_main) rate_cnt++;
            check(out_main == e.o, {e.tag, " main out"}, out_main, e.o);
            check(out_byp == e.b, {e.tag, " R9 bypass out"}, out_byp, e.b);
            check(busy == e.bs && busy_b == e.bs, {e.tag, " R1 busy"}, busy, e.bs);
        end
    end

    task automatic settle();
        while (sbq.size() > 0) @(posedge clk);
        #2;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy == 0 && out_main == 0 && out_byp == 0, "R10 reset", out_main, 0);
        @(negedge clk);
        rst_n = 1;

        // R4: divisor 1.5 on the oscillator, 30 pulses -> 20 outputs
        cyc(1, 1, dword(6), 0, 0, 0, "R4");
        cyc(1, 1, dword(6), 0, 0, 0, "R4");
        settle(); rate_cnt = 0;
        for (int i = 0; i < 30; i++) cyc(1, 1, dword(6), 1, 0, 0, "R4");
        cyc(1, 1, dword(6), 0, 0, 0, "R4");
        settle();
        check(rate_cnt == 20, "R4 rate", rate_cnt, 20);

        // R3: ones in every bit outside the field must not matter
        rate_cnt = 0;
        for (int i = 0; i < 30; i++)
            cyc(1, 1, dword(6) | 32'hFFFF_03FF, 1, 0, 0, "R3");
        cyc(1, 1, dword(6) | 32'hFFFF_03FF, 0, 0, 0, "R3");
        settle();
        check(rate_cnt == 20, "R3 field position", rate_cnt, 20);

        // R6: divisor below unity, sparse pulses
        cyc(1, 1, dword(3), 0, 0, 0, "R6");
        settle(); rate_cnt = 0;
        for (int i = 0; i < 20; i++) cyc(1, 1, dword(3), i[0], 0, 0, "R6");
        cyc(1, 1, dword(3), 0, 0, 0, "R6");
        settle();
        check(rate_cnt == 10, "R6 below unity", rate_cnt, 10);

        // R5: zero divisor
        cyc(1, 1, dword(0), 0, 0, 0, "R5");
        settle(); rate_cnt = 0;
        for (int i = 0; i < 12; i++) cyc(1, 1, dword(0), 1, 0, 0, "R5");
        settle();
        check(rate_cnt == 0, "R5 zero divisor", rate_cnt, 0);

        // R7: every source number at unity divisor
        rate_cnt = 0;
        for (int s = 0; s < 16; s++) begin
            cyc(1, 4'(s), dword(4), 0, 0, 0, "R7");
            if (s >= 1 && s <= 9)
                cyc(1, 4'(s), dword(4), s == 1, 2'(s == 2) | 2'((s == 3) << 1),
                    6'((s >= 4) ? (1 << (s - 4)) : 0), "R7");
            else
                cyc(1, 4'(s), dword(4), 1, 2'b11, 6'h3F, "R7");
        end
        cyc(1, 0, dword(4), 0, 0, 0, "R7");
        settle();
        check(rate_cnt == 9, "R7 source decode", rate_cnt, 9);

        // R8: change divisor while a remainder is held
        cyc(1, 1, dword(6), 0, 0, 0, "R8");
        cyc(1, 1, dword(6), 1, 0, 0, "R8");
        cyc(1, 1, dword(6), 1, 0, 0, "R8");
        cyc(1, 1, dword(10), 1, 0, 0, "R8");
        for (int i = 0; i < 4; i++) cyc(1, 1, dword(10), 1, 0, 0, "R8");
        cyc(1, 2, dword(10), 0, 2'b01, 0, "R8");
        for (int i = 0; i < 4; i++) cyc(1, 2, dword(10), 0, 2'b01, 0, "R8");
        settle();

        // R2: disable mid-stream, then re-enable from a cleared accumulator
        cyc(1, 1, dword(6), 1, 0, 0, "R2");
        cyc(1, 1, dword(6), 1, 0, 0, "R2");
        for (int i = 0; i < 4; i++) cyc(0, 1, dword(6), 1, 0, 0, "R2");
        for (int i = 0; i < 4; i++) cyc(1, 1, dword(6), 1, 0, 0, "R2");
        cyc(1, 1, dword(6), 0, 0, 0, "R2");
        settle();

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule